// File: doc/BRIEF.md
# Cascadable Sum-of-Products Logic Block

This block is the combinational heart of a programmable logic region of sixteen cells. A switch matrix picks a fixed number of signals out of a wide global bus. Each cell has five product terms. Every term is an AND over the picked signals and the region's shared foldback bus, and each input of a term is set to true, complement or ignore.

Each term is either summed into the cell's OR gate or steered out as a control term. The cell's sum can absorb the sum of the cell just below it, so neighbours chain into sums of up to forty terms. A chain never spans more than eight cells. An XOR stage after the sum sets the polarity: its second input is a constant or the cell's fifth term. Each cell also drives the complement of one chosen term onto the regional foldback bus, and every cell in the region reads that bus.

All configuration arrives on static ports. The block holds no state.

Top module: `sop_logic_block`

## Requirements
- R1: Switch-matrix slot k outputs global-bus bit `cfg_sel[k*SELW +: SELW]`, or 0 when that index is not below GBUS_W. Global-bus bits that no slot selects have no effect on any output.
- R2: Each product term has one 2-bit code per input. Code 1 uses the input true and code 2 uses it complemented. Codes 0 and 3 ignore the input. A term whose inputs are all ignored evaluates to 1. Input j of term t in cell c has its code at bit offset ((c*5+t)*NIN+j)*2 of `cfg_and`. Inputs j < NSEL are switch-matrix slots, and j >= NSEL is foldback bit j-NSEL.
- R3: A cell's sum is the OR of those of its five terms whose route bit `cfg_route[c*5+t]` is 1. A term with route bit 0 contributes 0 to the sum.
- R4: `ctrl_out[c*5+t]` equals the term's value when its route bit is 0, and is 0 when its route bit is 1.
- R5: When `cfg_casc[c]` is 1, the sum of cell c-1 is ORed into the sum of cell c.
- R6: A cell whose index is a multiple of CHAIN_LEN (8) never receives a cascade, whatever its `cfg_casc` bit. A chain therefore holds at most 8 cells, which is 40 terms.
- R7: `cell_out[c]` is the sum XOR a second input chosen by `cfg_xor[c*2 +: 2]`. Code 0 selects constant 0, code 1 selects constant 1, and codes 2 and 3 select term 4 of the cell.
- R8: `fold_bus[c]` is the complement of term `cfg_fb[c*3 +: 3]` (0 to 4) of cell c, evaluated over its switch-matrix inputs only. Select codes 5 to 7 give 1.
- R9: Every cell's terms read the whole foldback bus, including the cell's own foldback bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gbus | input | GBUS_W | Global bus signals |
| cfg_sel | input | NSEL*SELW | Switch-matrix slot source indexes |
| cfg_and | input | NCELL*5*NIN*2 | AND-array input codes |
| cfg_route | input | NCELL*5 | Per-term route bit: 1 = into the sum, 0 = control term |
| cfg_xor | input | NCELL*2 | Per-cell XOR second-input mode |
| cfg_fb | input | NCELL*3 | Per-cell foldback term select |
| cfg_casc | input | NCELL | Per-cell cascade-in enable |
| cell_out | output | NCELL | Cell result after the XOR stage |
| ctrl_out | output | NCELL*5 | Steered control terms |
| fold_bus | output | NCELL | Regional foldback bus |

## Verification
The bench builds the block with its default parameters: a 64-bit global bus, 40 switch-matrix slots, 16 cells and chains of 8. This brings two complete chain groups into reach, together with the boundary between them at cell 8. Random configurations with sparse terms are compared against a behavioural sum-of-products model. Directed cases cover an all-ignore array, pure steering, a cascade travelling the full eight-cell chain from either group start, every XOR mode, out-of-range foldback selects and toggling of unselected global-bus bits.

// File: rtl/sop_pkg.sv
// Shared encodings for the sum-of-products logic block.
// Assumes: five product terms per cell; code values are fixed by R2/R7.
package sop_pkg;
    localparam int PT_PER_CELL = 5;

    typedef enum logic [1:0] {
        LIT_SKIP     = 2'd0,
        LIT_TRUE     = 2'd1,
        LIT_COMP     = 2'd2,
        LIT_SKIP_ALT = 2'd3
    } lit_code_e;

    typedef enum logic [1:0] {
        XS_ZERO     = 2'd0,
        XS_ONE      = 2'd1,
        XS_TERM     = 2'd2,
        XS_TERM_ALT = 2'd3
    } xor_mode_e;
endpackage

// File: rtl/sop_switch_matrix.sv
// Switch matrix: each output slot picks one global-bus bit by index.
// Assumes: out-of-range indexes yield 0; purely combinational.
module sop_switch_matrix #(
    parameter int GBUS_W = 64,
    parameter int NSEL   = 40,
    parameter int SELW   = (GBUS_W > 1) ? $clog2(GBUS_W) : 1
) (
    input  logic [GBUS_W-1:0]    gbus,
    input  logic [NSEL*SELW-1:0] cfg_sel,
    output logic [NSEL-1:0]      sel_out
);
    for (genvar k = 0; k < NSEL; k++) begin : g_slot
        // pick one global-bus bit for slot k
        always_comb begin
            sel_out[k] = 1'b0;
            for (int b = 0; b < GBUS_W; b++) begin
                if (int'(cfg_sel[k*SELW +: SELW]) == b) sel_out[k] = gbus[b];
            end
        end
    end
endmodule

// File: rtl/sop_pterm.sv
// One product term: AND of coded literals over global and regional inputs.
// Also reports the term over the global inputs alone (used for foldback).
// Assumes: codes per sop_pkg::lit_code_e, global inputs in the low code slots.
module sop_pterm
    import sop_pkg::*;
#(
    parameter int NG = 40,
    parameter int NR = 16,
    localparam int NIN = NG + NR
) (
    input  logic [NG-1:0]    g_in,
    input  logic [NR-1:0]    r_in,
    input  logic [NIN*2-1:0] code,
    output logic             term_full,
    output logic             term_glob
);
    // evaluate the literal AND over both input groups
    always_comb begin
        logic used;
        term_glob = 1'b1;
        for (int j = 0; j < NG; j++) begin
            if (lit_code_e'(code[j*2 +: 2]) == LIT_TRUE && !g_in[j]) term_glob = 1'b0;
            if (lit_code_e'(code[j*2 +: 2]) == LIT_COMP &&  g_in[j]) term_glob = 1'b0;
        end
        term_full = term_glob;
        for (int j = 0; j < NR; j++) begin
            if (lit_code_e'(code[(NG+j)*2 +: 2]) == LIT_TRUE && !r_in[j]) term_full = 1'b0;
            if (lit_code_e'(code[(NG+j)*2 +: 2]) == LIT_COMP &&  r_in[j]) term_full = 1'b0;
        end
        used = 1'b0;
        for (int j = 0; j < NIN; j++) used = used | (code[j*2] ^ code[j*2+1]);
        if (!used) assert_all_ignored_R2: assert (term_full && term_glob);
    end
endmodule

// File: rtl/sop_macrocell.sv
// One macrocell: five product terms, routed OR sum with cascade in,
// polarity XOR, control-term steering and the foldback term.
// Assumes: cascade input already gated by the enclosing block.
module sop_macrocell
    import sop_pkg::*;
#(
    parameter int NG = 40,
    parameter int NR = 16,
    localparam int NIN = NG + NR,
    localparam int NP  = PT_PER_CELL
) (
    input  logic [NG-1:0]       g_in,
    input  logic [NR-1:0]       r_in,
    input  logic [NP*NIN*2-1:0] cfg_and,
    input  logic [NP-1:0]       cfg_route,
    input  logic [1:0]          cfg_xor,
    input  logic [2:0]          cfg_fb,
    input  logic                casc_in,
    output logic                sum_out,
    output logic                cell_out,
    output logic [NP-1:0]       ctrl_out,
    output logic                fold_out
);
    logic [NP-1:0] t_full;
    logic [NP-1:0] t_glob;

    for (genvar t = 0; t < NP; t++) begin : g_term
        sop_pterm #(.NG(NG), .NR(NR)) u_term (
            .g_in      (g_in),
            .r_in      (r_in),
            .code      (cfg_and[t*NIN*2 +: NIN*2]),
            .term_full (t_full[t]),
            .term_glob (t_glob[t])
        );
    end

    // form sum, steering, polarity and foldback from the five terms
    always_comb begin
        logic xin;
        sum_out = casc_in;
        for (int t = 0; t < NP; t++) begin
            if (cfg_route[t]) sum_out = sum_out | t_full[t];
        end
        ctrl_out = t_full & ~cfg_route;
        case (xor_mode_e'(cfg_xor))
            XS_ZERO: xin = 1'b0;
            XS_ONE:  xin = 1'b1;
            default: xin = t_full[NP-1];
        endcase
        cell_out = sum_out ^ xin;
        case (cfg_fb)
            3'd0:    fold_out = ~t_glob[0];
            3'd1:    fold_out = ~t_glob[1];
            3'd2:    fold_out = ~t_glob[2];
            3'd3:    fold_out = ~t_glob[3];
            3'd4:    fold_out = ~t_glob[4];
            default: fold_out = 1'b1;
        endcase
        if (casc_in) assert_casc_reaches_sum_R5: assert (sum_out);
        if (|(t_full & cfg_route)) assert_routed_term_R3: assert (sum_out);
        assert_steer_exclusive_R4: assert ((ctrl_out & cfg_route) == '0);
        if (cfg_xor == 2'd0) assert_xor_pass_R7: assert (cell_out == sum_out);
        if (cfg_fb > 3'd4) assert_fold_range_R8: assert (fold_out);
    end
endmodule

// File: rtl/sop_logic_block.sv
// Logic block top: shared switch matrix, NCELL macrocells on one
// regional foldback bus, and cascade links grouped in chains of CHAIN_LEN.
// Assumes: static configuration; foldback taken from global-only terms
// so the regional bus forms no combinational loop.
module sop_logic_block
    import sop_pkg::*;
#(
    parameter int GBUS_W    = 64,
    parameter int NSEL      = 40,
    parameter int NCELL     = 16,
    parameter int CHAIN_LEN = 8,
    localparam int SELW = (GBUS_W > 1) ? $clog2(GBUS_W) : 1,
    localparam int NP   = PT_PER_CELL,
    localparam int NIN  = NSEL + NCELL
) (
    input  logic [GBUS_W-1:0]        gbus,
    input  logic [NSEL*SELW-1:0]     cfg_sel,
    input  logic [NCELL*NP*NIN*2-1:0] cfg_and,
    input  logic [NCELL*NP-1:0]      cfg_route,
    input  logic [NCELL*2-1:0]       cfg_xor,
    input  logic [NCELL*3-1:0]       cfg_fb,
    input  logic [NCELL-1:0]         cfg_casc,
    output logic [NCELL-1:0]         cell_out,
    output logic [NCELL*NP-1:0]      ctrl_out,
    output logic [NCELL-1:0]         fold_bus
);
    logic [NSEL-1:0]  sel;
    logic [NCELL-1:0] sum;
    logic [NCELL-1:0] cin;

    sop_switch_matrix #(.GBUS_W(GBUS_W), .NSEL(NSEL), .SELW(SELW)) u_matrix (
        .gbus    (gbus),
        .cfg_sel (cfg_sel),
        .sel_out (sel)
    );

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        if (c % CHAIN_LEN == 0) begin : g_head
            assign cin[c] = cfg_casc[c] & 1'b0;
        end else begin : g_link
            assign cin[c] = cfg_casc[c] & sum[c-1];
        end

        sop_macrocell #(.NG(NSEL), .NR(NCELL)) u_cell (
            .g_in      (sel),
            .r_in      (fold_bus),
            .cfg_and   (cfg_and[c*NP*NIN*2 +: NP*NIN*2]),
            .cfg_route (cfg_route[c*NP +: NP]),
            .cfg_xor   (cfg_xor[c*2 +: 2]),
            .cfg_fb    (cfg_fb[c*3 +: 3]),
            .casc_in   (cin[c]),
            .sum_out   (sum[c]),
            .cell_out  (cell_out[c]),
            .ctrl_out  (ctrl_out[c*NP +: NP]),
            .fold_out  (fold_bus[c])
        );
    end
endmodule

// File: tb/sop_logic_block_test.sv
module sop_logic_block_test;
    localparam int GW = 64, NSEL = 40, NC = 16, CH = 8, NP = 5;
    localparam int SELW = 6, NIN = NSEL + NC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [GW-1:0]          gbus;
    logic [NSEL*SELW-1:0]   cfg_sel;
    logic [NC*NP*NIN*2-1:0] cfg_and;
    logic [NC*NP-1:0]       cfg_route;
    logic [NC*2-1:0]        cfg_xor;
    logic [NC*3-1:0]        cfg_fb;
    logic [NC-1:0]          cfg_casc;
    logic [NC-1:0]          cell_out;
    logic [NC*NP-1:0]       ctrl_out;
    logic [NC-1:0]          fold_bus;

    logic [NC-1:0]    exp_out;
    logic [NC*NP-1:0] exp_ctrl;
    logic [NC-1:0]    exp_fold;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    sop_logic_block #(.GBUS_W(GW), .NSEL(NSEL), .NCELL(NC), .CHAIN_LEN(CH)) uut (
        .gbus(gbus), .cfg_sel(cfg_sel), .cfg_and(cfg_and), .cfg_route(cfg_route),
        .cfg_xor(cfg_xor), .cfg_fb(cfg_fb), .cfg_casc(cfg_casc),
        .cell_out(cell_out), .ctrl_out(ctrl_out), .fold_bus(fold_bus)
    );

    task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural sum-of-products model
    task automatic ref_model();
        logic [NSEL-1:0]  s;
        logic [NC*NP-1:0] gl, fu;
        logic [NC-1:0]    sm;
        logic [1:0]       cd;
        logic             v, acc, xv;
        int               f;
        for (int k = 0; k < NSEL; k++) begin
            f = int'(cfg_sel[k*SELW +: SELW]);
            s[k] = (f < GW) ? gbus[f] : 1'b0;
        end
        for (int i = 0; i < NC*NP; i++) begin
            v = 1'b1;
            for (int j = 0; j < NSEL; j++) begin
                cd = cfg_and[(i*NIN+j)*2 +: 2];
                if (cd == 2'd1 && !s[j]) v = 1'b0;
                if (cd == 2'd2 &&  s[j]) v = 1'b0;
            end
            gl[i] = v;
        end
        for (int c = 0; c < NC; c++) begin
            f = int'(cfg_fb[c*3 +: 3]);
            exp_fold[c] = (f < NP) ? ~gl[c*NP+f] : 1'b1;
        end
        for (int i = 0; i < NC*NP; i++) begin
            v = gl[i];
            for (int j = 0; j < NC; j++) begin
                cd = cfg_and[(i*NIN+NSEL+j)*2 +: 2];
                if (cd == 2'd1 && !exp_fold[j]) v = 1'b0;
                if (cd == 2'd2 &&  exp_fold[j]) v = 1'b0;
            end
            fu[i] = v;
        end
        for (int c = 0; c < NC; c++) begin
            acc = 1'b0;
            for (int t = 0; t < NP; t++) if (cfg_route[c*NP+t]) acc = acc | fu[c*NP+t];
            if (cfg_casc[c] && (c % CH) != 0) acc = acc | sm[c-1];
            sm[c] = acc;
            case (cfg_xor[c*2 +: 2])
                2'd0: xv = 1'b0;
                2'd1: xv = 1'b1;
                default: xv = fu[c*NP+4];
            endcase
            exp_out[c] = acc ^ xv;
        end
        exp_ctrl = fu & ~cfg_route;
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic full_compare(input string tag);
        settle();
        ref_model();
        check({tag, " R1 R3 R5 R7 R9 cell_out"}, 80'(cell_out), 80'(exp_out));
        check({tag, " R4 ctrl_out"}, 80'(ctrl_out), 80'(exp_ctrl));
        check({tag, " R8 fold_bus"}, 80'(fold_bus), 80'(exp_fold));
    endtask

    task automatic clear_cfg();
        cfg_sel = '0; cfg_and = '0; cfg_route = '0;
        cfg_xor = '0; cfg_fb = '0; cfg_casc = '0; gbus = '0;
    endtask

    task automatic rand_cfg();
        int n, j;
        for (int k = 0; k < NSEL; k++) cfg_sel[k*SELW +: SELW] = SELW'($urandom % GW);
        cfg_and = '0;
        for (int i = 0; i < NC*NP; i++) begin
            n = $urandom % 4;
            for (int m = 0; m < n; m++) begin
                j = $urandom % NIN;
                cfg_and[(i*NIN+j)*2 +: 2] = 2'(1 + ($urandom % 2));
            end
            if ($urandom % 8 == 0) cfg_and[(i*NIN + ($urandom % NIN))*2 +: 2] = 2'd3;
        end
        for (int i = 0; i < NC*NP; i++) cfg_route[i] = ($urandom % 4) != 0;
        for (int c = 0; c < NC; c++) begin
            cfg_xor[c*2 +: 2] = 2'($urandom % 4);
            cfg_fb[c*3 +: 3]  = 3'($urandom % 8);
            cfg_casc[c]       = $urandom % 2;
        end
    endtask

    initial begin
        logic [NC-1:0]    o_before;
        logic [NC*NP-1:0] c_before;
        logic [NC-1:0]    f_before;
        void'($urandom(32'h5eed_1234));
        clear_cfg();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // reset-state configuration: all ignored, nothing routed
        settle();
        check("R2 R4 idle cell_out", 80'(cell_out), 80'(16'h0000));
        check("R4 idle ctrl_out", 80'(ctrl_out), {80{1'b0}} | {NC*NP{1'b1}});
        check("R8 idle fold_bus", 80'(fold_bus), 80'(16'h0000));

        // R2: all-ignore terms routed into the sums give 1
        cfg_route = '1;
        settle();
        check("R2 all-ignore sum", 80'(cell_out), 80'(16'hFFFF));
        check("R4 routed ctrl zero", 80'(ctrl_out), 80'(0));

        // R2: codes 3 are ignored, code 2 on a 1 input clears the term
        clear_cfg();
        cfg_route = '1;
        gbus = 64'h1;
        for (int c = 0; c < NC; c++)
            for (int t = 0; t < NP; t++) cfg_and[((c*NP+t)*NIN)*2 +: 2] = 2'd3;
        cfg_and[((3*NP+0)*NIN)*2 +: 2] = 2'd2;
        for (int t = 1; t < NP; t++) cfg_route[3*NP+t] = 1'b0;
        settle();
        check("R2 skip-alt and complement", 80'(cell_out), 80'(16'hFFF7));

        // R6 R5: cascade runs through the full first group, stops at cell 8
        clear_cfg();
        cfg_route[0] = 1'b1;
        cfg_casc = '1;
        settle();
        check("R5 R6 chain from cell 0", 80'(cell_out), 80'(16'h00FF));
        cfg_route = '0;
        cfg_route[8*NP] = 1'b1;
        settle();
        check("R5 R6 chain from cell 8", 80'(cell_out), 80'(16'hFF00));
        cfg_casc[4] = 1'b0;
        cfg_route = '0;
        cfg_route[0] = 1'b1;
        settle();
        check("R5 broken link", 80'(cell_out), 80'(16'h000F));

        // R7: XOR modes on a cell whose sum is 1 and term 4 is 1
        clear_cfg();
        cfg_route[0] = 1'b1;
        cfg_xor[1:0] = 2'd1;
        settle();
        check("R7 const one inverts", 80'(cell_out[0]), 80'(0));
        cfg_xor[1:0] = 2'd2;
        cfg_xor[3:2] = 2'd3;
        settle();
        check("R7 term4 mode", 80'(cell_out[1:0]), 80'(2'b10));

        // R8: select codes 5..7 give 1, code 0 gives complement of term 0
        cfg_fb = '0;
        for (int c = 0; c < NC; c += 2) cfg_fb[c*3 +: 3] = 3'(5 + (c % 3));
        settle();
        check("R8 fold select range", 80'(fold_bus), 80'(16'h5555));

        // R9 R8: a term reading another cell's foldback bit
        clear_cfg();
        cfg_fb[2*3 +: 3] = 3'd7;
        cfg_and[((9*NP+0)*NIN + NSEL + 2)*2 +: 2] = 2'd1;
        cfg_and[((9*NP+1)*NIN + NSEL + 9)*2 +: 2] = 2'd2;
        cfg_route[9*NP] = 1'b1;
        settle();
        check("R9 regional read", 80'(cell_out), 80'(16'h0200));
        check("R9 own fold in ctrl", 80'(ctrl_out[9*NP+1]), 80'(1));

        // R1: unselected global bits have no effect
        rand_cfg();
        for (int k = 0; k < NSEL; k++) cfg_sel[k*SELW +: SELW] = SELW'(k);
        gbus = {$urandom, $urandom};
        full_compare("R1 base");
        o_before = cell_out; c_before = ctrl_out; f_before = fold_bus;
        gbus[GW-1:NSEL] = ~gbus[GW-1:NSEL];
        settle();
        check("R1 unselected cell_out", 80'(cell_out), 80'(o_before));
        check("R1 unselected ctrl_out", 80'(ctrl_out), 80'(c_before));
        check("R1 unselected fold_bus", 80'(fold_bus), 80'(f_before));

        // random configurations against the model
        for (int n = 0; n < 150; n++) begin
            rand_cfg();
            for (int v = 0; v < 3; v++) begin
                gbus = {$urandom, $urandom};
                full_compare("random");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule